// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a recovery watchdog for a small 8-bit controller. After any hardware reset it sits disarmed and ignores machine-cycle ticks. Software arms it by writing two key bytes to its service register on the register bus: first 0x1E, then 0xE1. Once armed, it counts machine cycles in a 14-bit counter. Writing the same two-byte pair again clears the counter. If software lets the counter run up to its limit, the block drives a reset pulse of fixed length on its reset output and disarms itself.

The counter pauses in power-down. After a wake-up it stays paused until the wake-up interrupt line has returned high. A configuration bit chooses whether counting also pauses while the CPU idles. A second configuration bit keeps the reset output from being driven on timeout. The service register is write-only, and the counter has no read or write path.

The block runs on the oscillator clock. The machine-cycle tick arrives as a single-cycle enable on that clock.

Top module: `keyed_watchdog`

## Requirements
- R1: After hardware reset, the watchdog is disarmed and the counter is zero. `rstOut` is low, and machine-cycle ticks produce no timeout however many arrive.
- R2: Arming uses bus writes to address 0xA6. A write of 0xE1 that comes after a write of 0x1E, with no other write to 0xA6 between them, arms the watchdog and clears the counter. Writes to any other address are ignored and do not break a pending sequence.
- R3: While armed, the same key pair clears the counter. A key-completing write in the same clock as the tick that would overflow wins: the counter clears and no timeout occurs.
- R4: While armed and not gated off, each tick raises the counter by one. The tick that would bring the 14-bit counter to 0x3FFF causes a timeout instead, so with a tick on every clock `rstOut` rises on the 16383rd clock edge after the arming edge.
- R5: Only a hardware reset or a timeout disarms the watchdog. After a timeout it stays disarmed until the key pair is written again.
- R6: On a timeout, `rstOut` is high for exactly 98 consecutive oscillator clocks, starting right after the timeout edge.
- R7: While `powerDown` is high, nothing is counted. After `powerDown` falls, counting stays held while `wakeLineN` is low. It resumes from the held value starting with the edge after the first edge that sees `wakeLineN` high.
- R8: With `cfgIdleHalt` at 0, counting continues while `idleMode` is high. With `cfgIdleHalt` at 1, counting pauses in idle and resumes from the held value when the pause condition ends.
- R9: With `cfgRstOutDis` at 1 at the timeout edge, `rstOut` stays low. The timeout still disarms the watchdog and clears the counter.
- R10: A write of 0xE1 to 0xA6 that does not directly follow a 0x1E write there is ignored. Any value other than 0x1E written to 0xA6 cancels a pending first key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| busWrEn | input | 1 | Register-bus write strobe, one clock per write |
| busAddr | input | 8 | Register-bus address |
| busWrData | input | 8 | Register-bus write data |
| cycleTick | input | 1 | Machine-cycle enable, one clock wide |
| idleMode | input | 1 | CPU is in idle |
| powerDown | input | 1 | Chip is in power-down |
| wakeLineN | input | 1 | Wake-up interrupt line, low while held |
| cfgIdleHalt | input | 1 | 1 pauses counting during idle |
| cfgRstOutDis | input | 1 | 1 keeps the reset output undriven on timeout |
| rstOut | output | 1 | Timeout reset pulse, active high |

## Verification
The bench goes after the exact overflow count. A design that is off by one tick would raise the reset one clock early or late, or would let the counter show 0x3FFF. It checks the pulse length at 98 clocks, which a wrong decrement or reload would lengthen or shorten. It checks a service write that lands on the final tick, which a design with the wrong priority would answer with a reset.

Key handling is tested with a lone second key and with a first key followed by a wrong byte. A bad decoder would arm on either of these. A write to another address between the two keys must not break the sequence, or arming would be lost.

For gating, the bench measures the time to reset after power-down and idle pauses. A design that resumed before the wake line went high, or that cleared instead of held the count, would shift the reset edge. Finally, it confirms that a timeout with the output suppressed still disarms. A design that stayed armed would fire a second reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic clearCnt;   // zero the cycle counter
    logic countEn;    // advance the cycle counter by one
    logic loadPulse;  // start a reset pulse
  } wdtStrobe_t;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              cycleTick,
  input  logic              idleMode,
  input  logic              powerDown,
  input  logic              wakeLineN,
  input  logic              cfgIdleHalt,
  input  logic              cfgRstOutDis,
  input  logic              atLimit,
  output wdtStrobe_t        strobe
);

  logic armed;
  logic keyPending;
  logic wakeHold;
  logic svcWrite;
  logic keyOk;
  logic gateOpen;
  logic tickGo;
  logic overflow;

  assign svcWrite = busWrEn && (busAddr == SVC_ADDR);
  assign keyOk    = svcWrite && (busWrData == KEY_SECOND) && keyPending;
  assign gateOpen = !powerDown && !wakeHold && !(idleMode && cfgIdleHalt);
  assign tickGo   = armed && cycleTick && gateOpen;
  assign overflow = tickGo && atLimit && !keyOk;

  always_comb begin
    strobe           = '0;
    strobe.clearCnt  = keyOk || overflow;
    strobe.countEn   = tickGo && !atLimit && !keyOk;
    strobe.loadPulse = overflow && !cfgRstOutDis;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed      <= 1'b0;
      keyPending <= 1'b0;
      wakeHold   <= 1'b0;
    end else begin
      if (overflow) armed <= 1'b0;
      else if (keyOk) armed <= 1'b1;

      if (overflow) keyPending <= 1'b0;
      else if (svcWrite) keyPending <= (busWrData == KEY_FIRST);

      wakeHold <= powerDown || (wakeHold && !wakeLineN);
    end
  end

  // R1: a disarmed watchdog neither counts nor fires
  assert_quiet_disarmed_R1: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (!strobe.countEn && !strobe.loadPulse));

  // R5: disarming only follows a timeout
  assert_disarm_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(armed) |-> $past(tickGo && atLimit));

  // R7: power-down and the wake hold block counting
  assert_pd_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (powerDown || wakeHold) |-> !strobe.countEn);

  // R8: idle pause blocks counting when selected
  assert_idle_halt_R8: assert property (@(posedge clk) disable iff (!rstN)
    (idleMode && cfgIdleHalt) |-> !strobe.countEn);

  // R9: suppressed output never launches a pulse
  assert_rstout_dis_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgRstOutDis |-> !strobe.loadPulse);

  // R10: a lone second key leaves the watchdog disarmed
  assert_lone_key_R10: assert property (@(posedge clk) disable iff (!rstN)
    (svcWrite && (busWrData == KEY_SECOND) && !keyPending && !armed) |=> !armed);

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int PULSE_LEN = 98
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdtStrobe_t strobe,
  output logic       atLimit,
  output logic       rstOut
);

  localparam int PULSE_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [PULSE_W-1:0] PULSE_INIT = PULSE_W'(PULSE_LEN);

  logic [CNT_W-1:0]   cycleCnt;
  logic [PULSE_W-1:0] pulseCnt;

  assign atLimit = (cycleCnt == CNT_LAST);
  assign rstOut  = (pulseCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt <= '0;
    end else if (strobe.clearCnt) begin
      cycleCnt <= '0;
    end else if (strobe.countEn) begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobe.loadPulse) begin
      pulseCnt <= PULSE_INIT;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  // R4: the counter never holds its all-ones value
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    cycleCnt != {CNT_W{1'b1}});

  // R4: a count strobe advances by exactly one
  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countEn |=> (cycleCnt == $past(cycleCnt) + 1'b1));

  // R3: a clear strobe leaves the counter at zero
  assert_cnt_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCnt |=> (cycleCnt == '0));

  // R6: pulse starts at full length
  assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPulse |=> (pulseCnt == PULSE_INIT));

  // R6: a running pulse shortens by one per clock
  assert_pulse_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((pulseCnt != '0) && !strobe.loadPulse) |=> (pulseCnt == $past(pulseCnt) - 1'b1));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W = 14,
  parameter int PULSE_LEN = 98,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              cycleTick,
  input  logic              idleMode,
  input  logic              powerDown,
  input  logic              wakeLineN,
  input  logic              cfgIdleHalt,
  input  logic              cfgRstOutDis,
  output logic              rstOut
);

  wdtStrobe_t strobe;
  logic       atLimit;

  wdt_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .cycleTick(cycleTick), .idleMode(idleMode),
    .powerDown(powerDown), .wakeLineN(wakeLineN), .cfgIdleHalt(cfgIdleHalt),
    .cfgRstOutDis(cfgRstOutDis), .atLimit(atLimit), .strobe(strobe)
  );

  wdt_datapath #(
    .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .atLimit(atLimit), .rstOut(rstOut)
  );

endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic [7:0] busWrData = 8'h00;
  logic       cycleTick = 1'b1;
  logic       idleMode = 1'b0;
  logic       powerDown = 1'b0;
  logic       wakeLineN = 1'b1;
  logic       cfgIdleHalt = 1'b0;
  logic       cfgRstOutDis = 1'b0;
  logic       rstOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string curReq = "R1";

  always #10 clk = ~clk;  // 50 MHz

  keyed_watchdog u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .cycleTick(cycleTick), .idleMode(idleMode),
    .powerDown(powerDown), .wakeLineN(wakeLineN), .cfgIdleHalt(cfgIdleHalt),
    .cfgRstOutDis(cfgRstOutDis), .rstOut(rstOut)
  );

  // Behavioural reference model, updated on each rising edge
  int mCnt = 0, mPulse = 0;
  bit mArmed = 0, mPend = 0, mHold = 0;

  always @(posedge clk) begin
    bit svc, key, gate, ovf;
    if (!rstN) begin
      mCnt = 0; mPulse = 0; mArmed = 0; mPend = 0; mHold = 0;
    end else begin
      svc  = busWrEn && busAddr == 8'hA6;
      key  = svc && busWrData == 8'hE1 && mPend;
      gate = mArmed && cycleTick && !powerDown && !mHold && !(idleMode && cfgIdleHalt);
      ovf  = gate && mCnt == 16382 && !key;
      if (ovf && !cfgRstOutDis) mPulse = 98;
      else if (mPulse > 0) mPulse = mPulse - 1;
      if (key || ovf) mCnt = 0;
      else if (gate) mCnt = mCnt + 1;
      if (ovf) mArmed = 0;
      else if (key) mArmed = 1;
      if (ovf) mPend = 0;
      else if (svc) mPend = (busWrData == 8'h1E);
      mHold = powerDown || (mHold && !wakeLineN);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rstOut !== (mPulse != 0)) begin
        failures++;
        $display("FAIL %s model compare rstOut actual=%0b expected=%0b at %0t",
                 curReq, rstOut, (mPulse != 0), $time);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 8'h00; busWrData = 8'h00;
  endtask

  task automatic armKey();
    busWrite(8'hA6, 8'h1E);
    busWrite(8'hA6, 8'hE1);
  endtask

  // Clocks until rstOut is seen high, or -1 if not within limit.
  task automatic waitRise(input int limit, output int elapsed);
    elapsed = -1;
    for (int n = 0; n < limit; n++) begin
      if (rstOut) begin elapsed = n; return; end
      @(negedge clk);
    end
    if (rstOut) elapsed = limit;
  endtask

  task automatic measureHigh(output int width);
    width = 0;
    while (rstOut && width < 1000) begin
      width++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished (%s)", curReq);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int el, wd;
    repeat (3) @(negedge clk);
    check(rstOut == 1'b0, "R1 rstOut during reset", rstOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rstOut == 1'b0, "R1 rstOut after reset", rstOut, 0);

    // R10: lone second key, broken sequence; R1: no timeout while disarmed
    curReq = "R10";
    busWrite(8'hA6, 8'hE1);
    busWrite(8'hA6, 8'h1E);
    busWrite(8'hA6, 8'h55);
    busWrite(8'hA6, 8'hE1);
    waitRise(16500, el);
    check(el == -1, "R10 R1 no timeout without valid key pair", el, -1);

    // R2/R4/R6: arm across a foreign-address write, measure rise and width
    curReq = "R2";
    busWrite(8'hA6, 8'h1E);
    busWrite(8'h80, 8'h33);
    busWrite(8'hA6, 8'hE1);
    curReq = "R4";
    waitRise(17000, el);
    check(el == 16383, "R2 R4 clocks from arming to rstOut rise", el, 16383);
    curReq = "R6";
    measureHigh(wd);
    check(wd == 98, "R6 reset pulse width", wd, 98);
    curReq = "R5";
    waitRise(16500, el);
    check(el == -1, "R5 disarmed after timeout", el, -1);

    // R3: service on the final tick wins, then a full period follows
    curReq = "R3";
    armKey();
    busWrite(8'hA6, 8'h1E);
    repeat (16381) @(negedge clk);
    busWrite(8'hA6, 8'hE1);
    waitRise(17000, el);
    check(el == 16383, "R3 service on final tick restarts period", el, 16383);
    measureHigh(wd);
    check(wd == 98, "R6 second pulse width", wd, 98);

    // R7: power-down pause and wake-line hold
    curReq = "R7";
    armKey();
    repeat (10000) @(negedge clk);
    powerDown = 1'b1;
    repeat (3000) @(negedge clk);
    check(rstOut == 1'b0, "R7 no reset during power-down", rstOut, 0);
    powerDown = 1'b0; wakeLineN = 1'b0;
    repeat (40) @(negedge clk);
    wakeLineN = 1'b1;
    waitRise(8000, el);
    check(el == 6384, "R7 clocks from wake line high to rise", el, 6384);
    measureHigh(wd);

    // R8: idle with and without the halt bit
    curReq = "R8";
    idleMode = 1'b1; cfgIdleHalt = 1'b1;
    armKey();
    repeat (3000) @(negedge clk);
    cfgIdleHalt = 1'b0;
    repeat (8000) @(negedge clk);
    cfgIdleHalt = 1'b1;
    repeat (2000) @(negedge clk);
    check(rstOut == 1'b0, "R8 no reset while halted in idle", rstOut, 0);
    cfgIdleHalt = 1'b0;
    waitRise(9000, el);
    check(el == 8383, "R8 remaining idle count after pause", el, 8383);
    measureHigh(wd);
    idleMode = 1'b0;

    // R9: suppressed output still disarms
    curReq = "R9";
    cfgRstOutDis = 1'b1;
    armKey();
    waitRise(16500, el);
    check(el == -1, "R9 no pulse with output disabled", el, -1);
    cfgRstOutDis = 1'b0;
    waitRise(16500, el);
    check(el == -1, "R9 suppressed timeout left watchdog disarmed", el, -1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule